// File: doc/BRIEF.md
# Scaled Indexed Address Generator

This block forms the effective address of a memory instruction from a base register value, an index register value shifted left by a small scale amount, and a signed displacement. The displacement normally comes from a short 13-bit field carried in the instruction. A wider constant from a prefix unit can take its place when one is supplied. An index-enable input drops the index term for base-plus-displacement forms.

The address is registered and appears one cycle after the request. Each request is tagged as either a memory access or an address-only operation. A memory access raises a request strobe toward the load/store path. An address-only operation does not touch memory. It instead raises a register write-back strobe that carries the destination register number and the computed address as the value to write. All arithmetic wraps modulo 2^64.

Top module: `agu_ea_gen`

## Requirements
- R1: When `req_vld_i` is high, the address presented one cycle later on `ea_o` equals `base_i + (index term) + (displacement)` for the inputs of the request cycle.
- R2: The index term is `index_i` shifted left by `scale_i` bit positions. `scale_i` is 3 bits wide, so the shift ranges from 0 to 7, and bits shifted past bit 63 are lost.
- R3: The native displacement `disp_i` is a 13-bit two's-complement value. Bit 12 is its sign and is copied into bits 63..13. This covers -4096 to +4095.
- R4: When `xdisp_vld_i` is high, the 64-bit `xdisp_i` is used as the displacement and `disp_i` has no effect on the result.
- R5: When `idx_en_i` is low, the index term is zero, and `index_i` and `scale_i` have no effect on the result.
- R6: `ea_vld_o` is high exactly in the cycle after a cycle with `req_vld_i` high, and low in the cycle after a cycle with `req_vld_i` low.
- R7: A request with `addr_only_i` high produces `wb_en_o` high, `mem_req_o` low, `wb_reg_o` equal to the requested `dst_i`, and `wb_data_o` equal to `ea_o` in the following cycle.
- R8: A request with `addr_only_i` low produces `mem_req_o` high and `wb_en_o` low in the following cycle.
- R9: Carries out of bit 63 of the sum are discarded, so the result wraps modulo 2^64.
- R10: While synchronous active-low reset `rst_n` is low, `ea_vld_o`, `mem_req_o` and `wb_en_o` are low and `ea_o` is zero on the following edge.
- R11: In a cycle with `req_vld_i` low, `ea_o` and `wb_data_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | Request valid |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| scale_i | input | 3 | Left shift amount applied to the index |
| idx_en_i | input | 1 | Index term enabled |
| disp_i | input | 13 | Signed native displacement |
| xdisp_vld_i | input | 1 | Extended displacement present |
| xdisp_i | input | 64 | Extended displacement from the prefix unit |
| addr_only_i | input | 1 | Address-only operation (write address to a register) |
| dst_i | input | 5 | Destination register number |
| ea_vld_o | output | 1 | Registered address valid |
| ea_o | output | 64 | Registered effective address |
| mem_req_o | output | 1 | Memory access request |
| wb_en_o | output | 1 | Register write-back enable |
| wb_reg_o | output | 5 | Write-back destination register |
| wb_data_o | output | 64 | Write-back value |

## Verification
The extended displacement override and the index disable can both apply to the same request. In that case the sum must reduce to the base plus the 64-bit prefix constant, regardless of the native field, the index or the scale. The bench provokes this with directed vectors that place junk in `disp_i`, `index_i` and `scale_i` while both controls are active. Its random stream also sets each control independently with even odds, so the pairing recurs often. Every result is compared with a bench function that evaluates the sum from the requirement, and an address-only flag on the same request must route the same value to write-back.

// File: rtl/agu_pkg.sv
// Package: shared widths and the result record of the address generator.
// Assumes a flat 64-bit address space with modulo arithmetic.
package agu_pkg;
    parameter int unsigned ADDR_W  = 64;
    parameter int unsigned DISP_W  = 13;
    parameter int unsigned SCALE_W = 3;
    parameter int unsigned REG_W   = 5;

    typedef struct packed {
        logic              vld;
        logic              addr_only;
        logic [REG_W-1:0]  dst;
    } agu_tag_t;
endpackage

// File: rtl/agu_disp_sel.sv
// Displacement selector: sign-extends the short instruction field to the
// address width, or passes the prefix constant through when it is present.
// Assumes DISP_W < ADDR_W.
module agu_disp_sel #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned DISP_W = 13
) (
    input  logic [DISP_W-1:0] disp_i,
    input  logic              xdisp_vld_i,
    input  logic [ADDR_W-1:0] xdisp_i,
    output logic [ADDR_W-1:0] disp_o
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] native_sx;

    // Replicate the sign bit of the short field into the upper bits.
    always_comb begin
        native_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end

    // Prefer the prefix constant when the prefix unit supplies one.
    always_comb begin
        disp_o = xdisp_vld_i ? xdisp_i : native_sx;
    end
endmodule

// File: rtl/agu_index_scaler.sv
// Index scaler: shifts the index left by the scale amount, or yields zero
// when no index register takes part. Bits shifted past the top are lost.
// Assumes SCALE_W is small (a few bits) so each stage is one mux level.
module agu_index_scaler #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned SCALE_W = 3
) (
    input  logic [ADDR_W-1:0]  index_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               idx_en_i,
    output logic [ADDR_W-1:0]  term_o
);
    logic [ADDR_W-1:0] stage [SCALE_W+1];

    // Gate the index before shifting so a disabled index costs nothing.
    always_comb begin
        stage[0] = idx_en_i ? index_i : '0;
    end

    // One logarithmic shifter stage per scale bit.
    for (genvar s = 0; s < SCALE_W; s++) begin : g_shift
        always_comb begin
            stage[s+1] = scale_i[s] ? (stage[s] << (2**s)) : stage[s];
        end
    end

    // The last stage is the scaled index term.
    always_comb begin
        term_o = stage[SCALE_W];
    end
endmodule

// File: rtl/agu_add3.sv
// Three-operand adder modulo 2^ADDR_W. USE_CSA picks a carry-save
// compression followed by one carry-propagate add, or a plain chained sum.
// Assumes both variants must give identical results; only depth differs.
module agu_add3 #(
    parameter int unsigned ADDR_W  = 64,
    parameter bit          USE_CSA = 1'b1
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    input  logic [ADDR_W-1:0] c_i,
    output logic [ADDR_W-1:0] sum_o
);
    if (USE_CSA) begin : g_csa
        logic [ADDR_W-1:0] psum;
        logic [ADDR_W-1:0] pcar;

        // Compress three operands into a sum word and a carry word.
        always_comb begin
            psum = a_i ^ b_i ^ c_i;
            pcar = ((a_i & b_i) | (a_i & c_i) | (b_i & c_i)) << 1;
        end

        // Single carry-propagate add; the top carry is dropped.
        always_comb begin
            sum_o = psum + pcar;
        end
    end else begin : g_chain
        // Two ripple additions in series; the top carries are dropped.
        always_comb begin
            sum_o = a_i + b_i + c_i;
        end
    end
endmodule

// File: rtl/agu_ea_gen.sv
// Effective address generator top. Combines base, scaled index and
// displacement, registers the address one cycle later, and steers the
// result either to a memory request or to a register write-back.
// Assumes the caller holds no request across cycles: one request per
// cycle with req_vld_i high. Reset is synchronous and active low.
module agu_ea_gen
    import agu_pkg::*;
#(
    parameter bit USE_CSA = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [ADDR_W-1:0]  index_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               idx_en_i,
    input  logic [DISP_W-1:0]  disp_i,
    input  logic               xdisp_vld_i,
    input  logic [ADDR_W-1:0]  xdisp_i,
    input  logic               addr_only_i,
    input  logic [REG_W-1:0]   dst_i,
    output logic               ea_vld_o,
    output logic [ADDR_W-1:0]  ea_o,
    output logic               mem_req_o,
    output logic               wb_en_o,
    output logic [REG_W-1:0]   wb_reg_o,
    output logic [ADDR_W-1:0]  wb_data_o
);
    logic [ADDR_W-1:0] disp_full;
    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] ea_next;
    logic [ADDR_W-1:0] ea_q;
    agu_tag_t          tag_d;
    agu_tag_t          tag_q;

    agu_disp_sel #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_disp (
        .disp_i      (disp_i),
        .xdisp_vld_i (xdisp_vld_i),
        .xdisp_i     (xdisp_i),
        .disp_o      (disp_full)
    );

    agu_index_scaler #(
        .ADDR_W  (ADDR_W),
        .SCALE_W (SCALE_W)
    ) u_scale (
        .index_i  (index_i),
        .scale_i  (scale_i),
        .idx_en_i (idx_en_i),
        .term_o   (idx_term)
    );

    agu_add3 #(
        .ADDR_W  (ADDR_W),
        .USE_CSA (USE_CSA)
    ) u_add (
        .a_i   (base_i),
        .b_i   (idx_term),
        .c_i   (disp_full),
        .sum_o (ea_next)
    );

    // Collect the request tag that travels alongside the address.
    always_comb begin
        tag_d.vld       = req_vld_i;
        tag_d.addr_only = addr_only_i;
        tag_d.dst       = dst_i;
    end

    // Tag register: valid follows every cycle, fields load with a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q.vld <= tag_d.vld;
            if (req_vld_i) begin
                tag_q.addr_only <= tag_d.addr_only;
                tag_q.dst       <= tag_d.dst;
            end
        end
    end

    // Address register: loads only on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q <= '0;
        end else if (req_vld_i) begin
            ea_q <= ea_next;
        end
    end

    // Steer the registered result to memory or to register write-back.
    always_comb begin
        ea_vld_o  = tag_q.vld;
        ea_o      = ea_q;
        mem_req_o = tag_q.vld & ~tag_q.addr_only;
        wb_en_o   = tag_q.vld &  tag_q.addr_only;
        wb_reg_o  = tag_q.dst;
        wb_data_o = ea_q;
    end
endmodule

// File: rtl/agu_ea_gen_chk.sv
// Checker for the effective address generator, bound to every instance.
// Watches only ports; each property refers to the request one cycle back.
module agu_ea_gen_chk
    import agu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_vld_i,
    input logic [ADDR_W-1:0]  base_i,
    input logic [ADDR_W-1:0]  index_i,
    input logic [SCALE_W-1:0] scale_i,
    input logic               idx_en_i,
    input logic [DISP_W-1:0]  disp_i,
    input logic               xdisp_vld_i,
    input logic [ADDR_W-1:0]  xdisp_i,
    input logic               addr_only_i,
    input logic [REG_W-1:0]   dst_i,
    input logic               ea_vld_o,
    input logic [ADDR_W-1:0]  ea_o,
    input logic               mem_req_o,
    input logic               wb_en_o,
    input logic [REG_W-1:0]   wb_reg_o,
    input logic [ADDR_W-1:0]  wb_data_o
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    // R6: valid follows the request with one cycle of latency.
    assert_vld_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> ea_vld_o);
    assert_vld_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> !ea_vld_o);

    // R7: address-only requests go to write-back with the same value.
    assert_addr_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && addr_only_i) |=>
            (wb_en_o && !mem_req_o && wb_data_o == ea_o && wb_reg_o == $past(dst_i)));

    // R8: memory requests raise the memory strobe only.
    assert_mem_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !addr_only_i) |=> (mem_req_o && !wb_en_o));

    // R11: the address holds while no request arrives.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> ($stable(ea_o) && $stable(wb_data_o)));

    // R4 and R5: prefix constant with no index gives base plus constant.
    assert_xdisp_noidx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && xdisp_vld_i && !idx_en_i) |=>
            ea_o == $past(base_i + xdisp_i));

    // R3 and R5: short field alone is sign-extended onto the base.
    assert_native_disp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && !xdisp_vld_i && !idx_en_i) |=>
            ea_o == $past(base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i}));

    // R2: scale zero with no displacement leaves base plus raw index.
    assert_unscaled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && idx_en_i && scale_i == '0 && xdisp_vld_i && xdisp_i == '0) |=>
            ea_o == $past(base_i + index_i));
endmodule

bind agu_ea_gen agu_ea_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld_i   (req_vld_i),
    .base_i      (base_i),
    .index_i     (index_i),
    .scale_i     (scale_i),
    .idx_en_i    (idx_en_i),
    .disp_i      (disp_i),
    .xdisp_vld_i (xdisp_vld_i),
    .xdisp_i     (xdisp_i),
    .addr_only_i (addr_only_i),
    .dst_i       (dst_i),
    .ea_vld_o    (ea_vld_o),
    .ea_o        (ea_o),
    .mem_req_o   (mem_req_o),
    .wb_en_o     (wb_en_o),
    .wb_reg_o    (wb_reg_o),
    .wb_data_o   (wb_data_o)
);

// File: tb/agu_ea_gen_tb.sv
// Bench for the effective address generator: directed corners then a
// seeded random stream, each result compared with a bench model.
module agu_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld_i = 1'b0;
    logic [63:0] base_i = '0;
    logic [63:0] index_i = '0;
    logic [2:0]  scale_i = '0;
    logic        idx_en_i = 1'b0;
    logic [12:0] disp_i = '0;
    logic        xdisp_vld_i = 1'b0;
    logic [63:0] xdisp_i = '0;
    logic        addr_only_i = 1'b0;
    logic [4:0]  dst_i = '0;
    logic        ea_vld_o;
    logic [63:0] ea_o;
    logic        mem_req_o;
    logic        wb_en_o;
    logic [4:0]  wb_reg_o;
    logic [63:0] wb_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    agu_ea_gen dut_i (
        .clk (clk), .rst_n (rst_n), .req_vld_i (req_vld_i),
        .base_i (base_i), .index_i (index_i), .scale_i (scale_i),
        .idx_en_i (idx_en_i), .disp_i (disp_i), .xdisp_vld_i (xdisp_vld_i),
        .xdisp_i (xdisp_i), .addr_only_i (addr_only_i), .dst_i (dst_i),
        .ea_vld_o (ea_vld_o), .ea_o (ea_o), .mem_req_o (mem_req_o),
        .wb_en_o (wb_en_o), .wb_reg_o (wb_reg_o), .wb_data_o (wb_data_o)
    );

    // Model of the requirement: base + index<<scale + displacement, mod 2^64.
    function automatic logic [63:0] model_ea(
        input logic [63:0] b, input logic [63:0] x, input logic [2:0] s,
        input logic en, input logic [12:0] d, input logic xv, input logic [63:0] xd);
        logic [63:0] term;
        logic [63:0] dsp;
        term = en ? (x << s) : 64'd0;
        dsp  = xv ? xd : {{51{d[12]}}, d};
        return b + term + dsp;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one request at a falling edge, check the registered result one cycle later.
    task automatic vec(input string req, input logic [63:0] b, input logic [63:0] x,
                       input logic [2:0] s, input logic en, input logic [12:0] d,
                       input logic xv, input logic [63:0] xd, input logic lea,
                       input logic [4:0] rd);
        logic [63:0] e;
        @(negedge clk);
        req_vld_i = 1'b1; base_i = b; index_i = x; scale_i = s; idx_en_i = en;
        disp_i = d; xdisp_vld_i = xv; xdisp_i = xd; addr_only_i = lea; dst_i = rd;
        e = model_ea(b, x, s, en, d, xv, xd);
        @(negedge clk);
        chk(req, ea_o, e);
        chk("R6 valid", {63'd0, ea_vld_o}, 64'd1);
        if (lea) begin
            chk("R7 wb_en", {63'd0, wb_en_o}, 64'd1);
            chk("R7 mem_req", {63'd0, mem_req_o}, 64'd0);
            chk("R7 wb_reg", {59'd0, wb_reg_o}, {59'd0, rd});
            chk("R7 wb_data", wb_data_o, e);
        end else begin
            chk("R8 mem_req", {63'd0, mem_req_o}, 64'd1);
            chk("R8 wb_en", {63'd0, wb_en_o}, 64'd0);
        end
        req_vld_i = 1'b0;
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20250611));
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 ea", ea_o, 64'd0);
        chk("R10 vld", {63'd0, ea_vld_o}, 64'd0);
        chk("R10 mem_req", {63'd0, mem_req_o}, 64'd0);
        chk("R10 wb_en", {63'd0, wb_en_o}, 64'd0);
        rst_n = 1'b1;

        // R1: plain three-term sum
        vec("R1 sum", 64'h1000, 64'h20, 3'd2, 1'b1, 13'd16, 1'b0, '0, 1'b0, 5'd0);
        // R2: every scale amount, including bits lost past the top
        for (int s = 0; s < 8; s++)
            vec("R2 scale", 64'h0, 64'hF000_0000_0000_0001, 3'(s), 1'b1, 13'd0, 1'b0, '0, 1'b0, 5'd1);
        // R3: displacement extremes
        vec("R3 disp max", 64'h8000, 64'h0, 3'd0, 1'b0, 13'h0FFF, 1'b0, '0, 1'b0, 5'd2);
        vec("R3 disp min", 64'h8000, 64'h0, 3'd0, 1'b0, 13'h1000, 1'b0, '0, 1'b0, 5'd2);
        vec("R3 disp -1", 64'h0, 64'h0, 3'd0, 1'b0, 13'h1FFF, 1'b0, '0, 1'b0, 5'd2);
        // R4: prefix constant overrides a junk short field
        vec("R4 xdisp", 64'h100, 64'h8, 3'd3, 1'b1, 13'h1ABC, 1'b1, 64'h0000_0123_4567_0000, 1'b0, 5'd3);
        // R5: index disabled with junk index and scale
        vec("R5 noidx", 64'h4000, 64'hDEAD_BEEF_0000_0000, 3'd7, 1'b0, 13'd8, 1'b0, '0, 1'b0, 5'd4);
        // R4 with R5 together, address-only
        vec("R4 R5 combo", 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 3'd5, 1'b0, 13'h1555, 1'b1, 64'h7FFF_0000_0000_0000, 1'b1, 5'd31);
        // R9: wraparound past bit 63
        vec("R9 wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'd0, 1'b0, 13'd1, 1'b0, '0, 1'b0, 5'd5);
        vec("R9 wrap idx", 64'h8000_0000_0000_0000, 64'h1000_0000_0000_0000, 3'd3, 1'b1, 13'h1FFF, 1'b0, '0, 1'b1, 5'd6);
        // R11 and R6: idle cycle holds the address and drops valid
        held = ea_o;
        @(negedge clk);
        base_i = 64'h5555; disp_i = 13'h0AA; index_i = 64'h77; idx_en_i = 1'b1;
        @(negedge clk);
        chk("R11 hold ea", ea_o, held);
        chk("R11 hold wb_data", wb_data_o, held);
        chk("R6 idle vld", {63'd0, ea_vld_o}, 64'd0);
        chk("R6 idle wb_en", {63'd0, wb_en_o}, 64'd0);

        // R1: seeded random stream across all controls
        for (int i = 0; i < 400; i++)
            vec("R1 random", r64(), r64(), 3'($urandom_range(0, 7)), 1'($urandom()),
                13'($urandom()), 1'($urandom()), r64(), 1'($urandom()), 5'($urandom()));

        // R10: reset mid-stream clears the outputs
        @(negedge clk);
        rst_n = 1'b0; req_vld_i = 1'b1;
        @(negedge clk);
        chk("R10 mid ea", ea_o, 64'd0);
        chk("R10 mid vld", {63'd0, ea_vld_o}, 64'd0);
        req_vld_i = 1'b0;
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule